// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block is a sequential 32-bit multiplier with a 64-bit result held in a pair of registers: HI holds the upper word and LO the lower word. A single start strobe launches one of six operations on two operands. The product of the operands, signed or unsigned, either replaces the HI:LO pair, is added to it, or is subtracted from it. All arithmetic wraps modulo 2^64. No overflow is flagged.

The multiplier consumes one multiplier bit per cycle, so an operation occupies the unit for XLEN+1 cycles after the start edge. While an operation runs, `busy` is high and the HI/LO read ports keep showing the values from before the operation. The new pair appears in the same cycle as the one-cycle `done` pulse. Software-visible moves into HI or LO use separate write strobes, which are accepted only while the unit is idle.

Top module: `hilo_mac_unit`

## Requirements
- R1: After reset, HI, LO, `busy` and `done` are all zero. After an operation, `hi_rdata` shows bits 63:32 of the 64-bit result and `lo_rdata` shows bits 31:0.
- R2: Operation code 0 is a signed multiply. Both operands are sign-extended to 64 bits, and their product replaces HI:LO.
- R3: Operation code 1 is an unsigned multiply. Both operands are zero-extended, and their product replaces HI:LO.
- R4: Operation codes 2 (signed product) and 3 (unsigned product) write HI:LO plus the product, modulo 2^64.
- R5: Operation codes 4 (signed product) and 5 (unsigned product) write HI:LO minus the product, modulo 2^64.
- R6: A start is accepted at a clock edge when the unit is idle.
  - From the next cycle, `busy` is high.
  - `done` is high for exactly one cycle, XLEN+1 edges after the accepting edge.
  - `busy` is low in the `done` cycle.
- R7: While `busy` is high, `hi_rdata` and `lo_rdata` keep the values they had before the operation started.
- R8: While the unit is idle, asserting `hi_we` loads `hi_wdata` into HI only, and asserting `lo_we` loads `lo_wdata` into LO only. The new value is visible after the edge. A write issued in the same cycle as an accepted start becomes the base for accumulation.
- R9: `hi_we` and `lo_we` are ignored while `busy` is high.
- R10: A start is ignored in two cases, with no effect on `busy`, `done`, HI or LO:
  - it arrives while `busy` is high;
  - it carries operation code 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch an operation (sampled when idle) |
| opcode | input | 3 | Operation select, codes 0..5 |
| opa | input | 32 | Multiplicand operand |
| opb | input | 32 | Multiplier operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse; HI/LO updated |
| hi_we | input | 1 | Direct write strobe for HI |
| hi_wdata | input | 32 | Data for a direct HI write |
| lo_we | input | 1 | Direct write strobe for LO |
| lo_wdata | input | 32 | Data for a direct LO write |
| hi_rdata | output | 32 | Current HI value |
| lo_rdata | output | 32 | Current LO value |

## Verification
Internal faults show up at the ports in different ways, and at different times:
- A corrupted partial product or a lost sign correction appears only at `done`, as a wrong HI:LO word. A wrong iteration count moves `done` away from edge XLEN+1.
- A mode latch that drifts turns an accumulate into an overwrite, which is visible only when HI:LO was non-zero beforehand.
- A leaky write gate changes `hi_rdata` in the middle of an operation, one edge after the illegal strobe.

The operands 0x80000000 squared and 0xFFFFFFFF squared stress the magnitude and negation paths. Wrap-around tests from all-ones and from zero expose a missing carry or borrow into HI.

// File: rtl/hilo_mac_pkg.sv
// Package: shared operation codes and accumulation modes for the HI/LO unit.
// Assumes operation code bit 0 selects unsigned and bits 2:1 select the mode.
package hilo_mac_pkg;

    typedef enum logic [2:0] {
        OP_MUL_S = 3'd0,
        OP_MUL_U = 3'd1,
        OP_ADD_S = 3'd2,
        OP_ADD_U = 3'd3,
        OP_SUB_S = 3'd4,
        OP_SUB_U = 3'd5
    } mac_op_e;

    typedef enum logic [1:0] {
        ACC_LOAD = 2'd0,
        ACC_ADD  = 2'd1,
        ACC_SUB  = 2'd2
    } acc_mode_e;

    // Operation codes 6 and 7 are reserved and must not launch anything.
    function automatic logic op_is_legal(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

endpackage

// File: rtl/hilo_mul_seq.sv
// Module: radix-2 sequential multiplier.
// It multiplies operand magnitudes with shift-and-add, one bit per cycle,
// and applies the sign at the output. It assumes the caller raises go only
// while the core is idle; a go during a run is ignored.
module hilo_mul_seq #(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              is_unsigned,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic              running,
    output logic              prod_valid,
    output logic [2*XLEN-1:0] prod
);
    localparam int PLEN = 2 * XLEN;
    localparam int CW   = $clog2(XLEN + 1);

    logic [PLEN-1:0] acc_q, mcand_q;
    logic [XLEN-1:0] mplier_q;
    logic [CW-1:0]   cnt_q;
    logic            neg_q;
    logic [XLEN-1:0] a_mag, b_mag;
    logic            a_neg, b_neg;

    // Operand magnitudes for the signed form; the unsigned form passes through.
    always_comb begin
        a_neg = !is_unsigned && a[XLEN-1];
        b_neg = !is_unsigned && b[XLEN-1];
        a_mag = a_neg ? (~a + XLEN'(1)) : a;
        b_mag = b_neg ? (~b + XLEN'(1)) : b;
    end

    // Iteration state: load on go, then add and shift once per multiplier bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            mcand_q    <= '0;
            mplier_q   <= '0;
            cnt_q      <= '0;
            neg_q      <= 1'b0;
            running    <= 1'b0;
            prod_valid <= 1'b0;
        end else begin
            prod_valid <= 1'b0;
            if (go && !running) begin
                acc_q    <= '0;
                mcand_q  <= {{XLEN{1'b0}}, a_mag};
                mplier_q <= b_mag;
                neg_q    <= a_neg ^ b_neg;
                cnt_q    <= CW'(XLEN);
                running  <= 1'b1;
            end else if (running) begin
                if (mplier_q[0]) begin
                    acc_q <= acc_q + mcand_q;
                end
                mcand_q  <= mcand_q << 1;
                mplier_q <= mplier_q >> 1;
                cnt_q    <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    running    <= 1'b0;
                    prod_valid <= 1'b1;
                end
            end
        end
    end

    // Sign restore on the finished magnitude product.
    assign prod = neg_q ? (~acc_q + PLEN'(1)) : acc_q;

    // R10: a go during a run must not reload the counter.
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (running && go) |=> (cnt_q == $past(cnt_q) - CW'(1)));

    // R6: the product is flagged only right after the final iteration.
    a_r6_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        prod_valid |-> (!running && $past(running)));

endmodule

// File: rtl/hilo_combine.sv
// Module: combines the finished product with the current HI:LO pair.
// The result is an overwrite, an add or a subtract, all modulo 2^PLEN.
// The module is purely combinational. It assumes the mode was latched when
// the operation started.
module hilo_combine
    import hilo_mac_pkg::*;
#(
    parameter int PLEN = 64
) (
    input  logic [1:0]      mode,
    input  logic [PLEN-1:0] hilo,
    input  logic [PLEN-1:0] prod,
    output logic [PLEN-1:0] result
);
    // Mode select; code 3 never reaches here because the top filters it.
    always_comb begin
        unique case (acc_mode_e'(mode))
            ACC_ADD: result = hilo + prod;
            ACC_SUB: result = hilo - prod;
            default: result = prod;
        endcase
    end

endmodule

// File: rtl/hilo_pair_regs.sv
// Module: the HI and LO architectural registers.
// A commit from the multiplier loads both halves. Direct writes load one
// half each, and only while the unit is not locked. A commit takes priority.
module hilo_pair_regs #(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              commit,
    input  logic [2*XLEN-1:0] result,
    input  logic              hi_we,
    input  logic [XLEN-1:0]   hi_wd,
    input  logic              lo_we,
    input  logic [XLEN-1:0]   lo_wd,
    output logic [XLEN-1:0]   hi_q,
    output logic [XLEN-1:0]   lo_q
);
    // Register update: a commit, or gated single-half writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (commit) begin
            hi_q <= result[2*XLEN-1:XLEN];
            lo_q <= result[XLEN-1:0];
        end else if (!lock) begin
            if (hi_we) hi_q <= hi_wd;
            if (lo_we) lo_q <= lo_wd;
        end
    end

    // R9: strobes during a locked, non-commit cycle leave both halves alone.
    a_r9_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !commit && (hi_we || lo_we)) |=> ($stable(hi_q) && $stable(lo_q)));

    // R8: an idle LO-only write leaves HI untouched.
    a_r8_lo_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && !commit && lo_we && !hi_we) |=> ($stable(hi_q) && lo_q == $past(lo_wd)));

endmodule

// File: rtl/hilo_mac_unit.sv
// Module: top of the HI/LO multiply-accumulate unit.
// It accepts a start when idle and the operation code is legal, and latches
// the accumulation mode. It runs the sequential multiplier, commits the
// combined result into HI/LO, and pulses done. It assumes inputs are
// synchronous to clk.
module hilo_mac_unit
    import hilo_mac_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      opcode,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            busy,
    output logic            done,
    input  logic            hi_we,
    input  logic [XLEN-1:0] hi_wdata,
    input  logic            lo_we,
    input  logic [XLEN-1:0] lo_wdata,
    output logic [XLEN-1:0] hi_rdata,
    output logic [XLEN-1:0] lo_rdata
);
    localparam int PLEN = 2 * XLEN;

    logic            accept;
    logic            core_running, core_valid;
    logic [PLEN-1:0] core_prod, combined;
    logic [1:0]      mode_q;
    logic            done_q;

    assign busy   = core_running || core_valid;
    assign accept = start && !busy && op_is_legal(opcode);

    // Mode latch and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 2'd0;
            done_q <= 1'b0;
        end else begin
            done_q <= core_valid;
            if (accept) mode_q <= opcode[2:1];
        end
    end
    assign done = done_q;

    hilo_mul_seq #(.XLEN(XLEN)) u_mul (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (accept),
        .is_unsigned (opcode[0]),
        .a           (opa),
        .b           (opb),
        .running     (core_running),
        .prod_valid  (core_valid),
        .prod        (core_prod)
    );

    hilo_combine #(.PLEN(PLEN)) u_comb (
        .mode   (mode_q),
        .hilo   ({hi_rdata, lo_rdata}),
        .prod   (core_prod),
        .result (combined)
    );

    hilo_pair_regs #(.XLEN(XLEN)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock   (busy),
        .commit (core_valid),
        .result (combined),
        .hi_we  (hi_we),
        .hi_wd  (hi_wdata),
        .lo_we  (lo_we),
        .lo_wd  (lo_wdata),
        .hi_q   (hi_rdata),
        .lo_q   (lo_rdata)
    );

    // R6: done lasts a single cycle.
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: busy can only end through a done pulse.
    a_r6_busy_exit: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R7: reads hold their old values until the commit cycle.
    a_r7_hold_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !core_valid) |=> ($stable(hi_rdata) && $stable(lo_rdata)));

    // R10: a reserved code never raises busy.
    a_r10_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !op_is_legal(opcode)) |=> !busy);

endmodule

// File: tb/sim_hilo_mac_unit.sv
module sim_hilo_mac_unit;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] opcode = '0;
    logic [31:0] opa = '0, opb = '0;
    logic hi_we = 1'b0, lo_we = 1'b0;
    logic [31:0] hi_wdata = '0, lo_wdata = '0;
    logic busy, done;
    logic [31:0] hi_rdata, lo_rdata;

    int checks = 0;
    int failures = 0;
    logic finished = 1'b0;
    logic [31:0] hi_m = '0, lo_m = '0;

    always #2.5 clk = ~clk;

    hilo_mac_unit #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .opa(opa), .opb(opb), .busy(busy), .done(done),
        .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata),
        .hi_rdata(hi_rdata), .lo_rdata(lo_rdata)
    );

    function automatic logic [63:0] ref_result(input logic [2:0] op, input logic [63:0] hilo,
                                               input logic [31:0] a, input logic [31:0] b);
        logic [63:0] ea, eb, p;
        ea = op[0] ? {32'b0, a} : {{32{a[31]}}, a};
        eb = op[0] ? {32'b0, b} : {{32{b[31]}}, b};
        p  = ea * eb;
        case (op[2:1])
            2'd1:    return hilo + p;
            2'd2:    return hilo - p;
            default: return p;
        endcase
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2, 3'd3: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic he, input logic [31:0] hv, input logic le, input logic [31:0] lv);
        @(negedge clk);
        hi_we = he; hi_wdata = hv; lo_we = le; lo_wdata = lv;
        @(posedge clk); #1;
        if (he) hi_m = hv;
        if (le) lo_m = lv;
        chk("R8 direct write", {hi_rdata, lo_rdata}, {hi_m, lo_m});
        @(negedge clk);
        hi_we = 1'b0; lo_we = 1'b0;
    endtask

    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic inj_wr, input logic inj_start);
        logic [63:0] exp;
        logic got;
        exp = ref_result(op, {hi_m, lo_m}, a, b);
        got = 1'b0;
        @(negedge clk);
        start = 1'b1; opcode = op; opa = a; opb = b;
        @(posedge clk); #1;
        for (int k = 1; k <= XLEN + 6 && !got; k++) begin
            @(negedge clk);
            start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
            if (inj_wr && k == 4) begin
                hi_we = 1'b1; lo_we = 1'b1; hi_wdata = 32'hDEAD0001; lo_wdata = 32'hBEEF0002;
            end
            if (inj_start && k == 6) begin
                start = 1'b1; opcode = 3'd1; opa = 32'd7; opb = 32'd9;
            end
            @(posedge clk); #1;
            if (k == 12) begin
                chk("R6 busy mid-run", {63'b0, busy}, 64'd1);
                chk(inj_wr ? "R9 write while busy" : "R7 hold while busy",
                    {hi_rdata, lo_rdata}, {hi_m, lo_m});
            end
            if (done) begin
                got = 1'b1;
                chk("R6 done latency", 64'(k), 64'(XLEN + 1));
                chk("R6 busy low at done", {63'b0, busy}, 64'd0);
                chk("R1 hi half", {32'b0, hi_rdata}, {32'b0, exp[63:32]});
                chk(inj_start ? "R10 start while busy" : op_tag(op),
                    {hi_rdata, lo_rdata}, exp);
            end
        end
        if (!got) chk("R6 done missing", 64'd0, 64'd1);
        hi_m = exp[63:32]; lo_m = exp[31:0];
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 reset hi/lo", {hi_rdata, lo_rdata}, 64'd0);
        chk("R1 reset busy/done", {62'b0, busy, done}, 64'd0);

        wr(1'b1, 32'h12345678, 1'b0, 32'hFFFFFFFF);
        wr(1'b0, 32'hFFFFFFFF, 1'b1, 32'h9ABCDEF0);

        run_op(3'd0, 32'h80000000, 32'h80000000, 1'b0, 1'b0);
        run_op(3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0);
        run_op(3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0);
        run_op(3'd0, 32'hFFFFFFFD, 32'd5, 1'b0, 1'b0);
        run_op(3'd1, 32'h80000000, 32'h80000000, 1'b0, 1'b0);

        // R4 carry wrap from all ones
        wr(1'b1, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF);
        run_op(3'd3, 32'd1, 32'd1, 1'b0, 1'b0);
        run_op(3'd2, 32'hFFFFFFFF, 32'd3, 1'b0, 1'b0);
        // R5 borrow wrap from zero
        wr(1'b1, 32'd0, 1'b1, 32'd0);
        run_op(3'd5, 32'd1, 32'd1, 1'b0, 1'b0);
        run_op(3'd4, 32'hFFFFFFFF, 32'd1, 1'b0, 1'b0);
        run_op(3'd4, 32'h80000000, 32'h80000000, 1'b0, 1'b0);

        // R9 and R10 injected during a run
        run_op(3'd2, 32'h00012345, 32'h00067890, 1'b1, 1'b0);
        run_op(3'd3, 32'hCAFEF00D, 32'h0BADBEEF, 1'b0, 1'b1);

        // R10 reserved codes
        for (int c = 6; c <= 7; c++) begin
            @(negedge clk);
            start = 1'b1; opcode = 3'(c); opa = 32'd3; opb = 32'd4;
            @(posedge clk); #1;
            @(negedge clk); start = 1'b0;
            repeat (3) @(posedge clk); #1;
            chk("R10 reserved code busy/done", {62'b0, busy, done}, 64'd0);
            chk("R10 reserved code hi/lo", {hi_rdata, lo_rdata}, {hi_m, lo_m});
        end

        // Random mix of all six operations.
        for (int n = 0; n < 60; n++) begin
            logic [2:0] rop;
            rop = 3'($urandom_range(0, 5));
            if (n % 10 == 0) wr(1'b1, $urandom, 1'b1, $urandom);
            run_op(rop, $urandom, $urandom, 1'b0, 1'b0);
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule